// File: doc/BRIEF.md
# Two-Step Subranging Error Corrector

This block sits after the digital side of a two-pass subranging converter. In one 14-bit word it receives the 7-bit code from the coarse pass and the 7-bit code from the fine pass. It merges them into a 12-bit sample. The residue between the passes is amplified by 32, so each coarse code step is worth 32 output LSBs. The fine code overlaps the coarse step, and that overlap absorbs small coarse-pass errors.

The fine code carries a fixed offset of 48 that centres its redundancy. The merged value is therefore coarse×32 + fine − 48, formed in signed arithmetic wide enough never to wrap. The block clamps a merged value outside 0..4095 to the nearest end of the range. It flags the overflow and reports its direction. The result sits in registers and is marked by a one-cycle valid strobe. It holds until the next valid input arrives.

Top module: `ec_corrector`

## Requirements
- R1: While reset is active and after its release, out_vld, out_data, out_ovf and out_pol are all 0.
- R2: The coarse code is in_code[13:7] and the fine code is in_code[6:0], both unsigned. The merged value is coarse×32 + fine − 48.
- R3: A merged value in 0..4095 appears unchanged on out_data, with out_ovf = 0 and out_pol = 0.
- R4: A merged value above 4095 gives out_data = 4095, out_ovf = 1 and out_pol = 1.
- R5: A merged value below 0 gives out_data = 0, out_ovf = 1 and out_pol = 0.
- R6: Each cycle with in_vld = 1 produces out_vld = 1 in the cycle after, with the result for that input. A cycle with in_vld = 0 produces out_vld = 0 in the cycle after, so back-to-back inputs give back-to-back pulses.
- R7: When in_vld = 0, in_code is ignored and out_data, out_ovf and out_pol keep their last values.
- R8: Merged values of exactly 0 and exactly 4095 are in range (out_ovf = 0), and 4096 and −1 are out of range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input word valid |
| in_code | input | 14 | Coarse code in bits 13:7, fine code in bits 6:0 |
| out_vld | output | 1 | One-cycle strobe marking a new result |
| out_data | output | 12 | Corrected, clamped sample |
| out_ovf | output | 1 | Merged value was outside 0..4095 |
| out_pol | output | 1 | Overflow direction: 1 above the top, 0 below the bottom |

## Verification
Every result is due exactly one rising edge after the cycle in which in_vld was sampled high. Its strobe lasts that one cycle only. The driver applies inputs on the falling edge and pushes the expected sample, flags and direction into a queue. The monitor samples on the falling edge that follows the capturing rising edge: it pops one entry per strobe, and in idle cycles it checks that the strobe is low and the outputs have not moved. Back-to-back inputs confirm one pop per cycle, and an empty queue at the end confirms that no strobe was lost or added.

// File: rtl/ec_pkg.sv
package ec_pkg;
    typedef enum logic [1:0] {
        RNG_IN   = 2'd0,
        RNG_HIGH = 2'd1,
        RNG_LOW  = 2'd2
    } rng_e;
endpackage

// File: rtl/ec_combine.sv
module ec_combine #(
    parameter int CODE_W = 7,
    parameter int SHIFT  = 5,
    parameter int OFFSET = 48,
    parameter int RAW_W  = 14
) (
    input  logic [2*CODE_W-1:0]      code,
    output logic signed [RAW_W-1:0]  raw
);
    localparam int PAD_W = RAW_W - CODE_W;
    localparam logic signed [RAW_W-1:0] OFS_S = RAW_W'(OFFSET);

    logic signed [RAW_W-1:0] coarse_s;
    logic signed [RAW_W-1:0] fine_s;

    always_comb begin
        coarse_s = signed'({{PAD_W{1'b0}}, code[2*CODE_W-1:CODE_W]});
        fine_s   = signed'({{PAD_W{1'b0}}, code[CODE_W-1:0]});
        raw      = (coarse_s <<< SHIFT) + fine_s - OFS_S;
    end
endmodule

// File: rtl/ec_clamp.sv
module ec_clamp
    import ec_pkg::*;
#(
    parameter int RAW_W = 14,
    parameter int OUT_W = 12
) (
    input  logic signed [RAW_W-1:0] raw,
    output logic [OUT_W-1:0]        data,
    output rng_e                    cls
);
    localparam logic signed [RAW_W-1:0] TOP_S = RAW_W'((1 << OUT_W) - 1);

    always_comb begin
        if (raw < 0) begin
            cls  = RNG_LOW;
            data = '0;
        end else if (raw > TOP_S) begin
            cls  = RNG_HIGH;
            data = '1;
        end else begin
            cls  = RNG_IN;
            data = raw[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/ec_corrector.sv
module ec_corrector
    import ec_pkg::*;
#(
    parameter int CODE_W = 7,
    parameter int SHIFT  = 5,
    parameter int OFFSET = 48,
    parameter int OUT_W  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [2*CODE_W-1:0]   in_code,
    output logic                  out_vld,
    output logic [OUT_W-1:0]      out_data,
    output logic                  out_ovf,
    output logic                  out_pol
);
    localparam int RAW_W = CODE_W + SHIFT + 2;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] data;
        logic             ovf;
        logic             pol;
    } res_t;

    logic signed [RAW_W-1:0] raw;
    logic [OUT_W-1:0]        clamp_data;
    rng_e                    clamp_cls;
    res_t                    res_d, res_q;

    ec_combine #(
        .CODE_W (CODE_W),
        .SHIFT  (SHIFT),
        .OFFSET (OFFSET),
        .RAW_W  (RAW_W)
    ) u_combine (
        .code (in_code),
        .raw  (raw)
    );

    ec_clamp #(
        .RAW_W (RAW_W),
        .OUT_W (OUT_W)
    ) u_clamp (
        .raw  (raw),
        .data (clamp_data),
        .cls  (clamp_cls)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_vld;
        if (in_vld) begin
            res_d.data = clamp_data;
            res_d.ovf  = (clamp_cls != RNG_IN);
            res_d.pol  = (clamp_cls == RNG_HIGH);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_vld  = res_q.vld;
    assign out_data = res_q.data;
    assign out_ovf  = res_q.ovf;
    assign out_pol  = res_q.pol;
endmodule

// File: rtl/ec_corrector_chk.sv
module ec_corrector_chk #(
    parameter int CODE_W = 7,
    parameter int SHIFT  = 5,
    parameter int OFFSET = 48,
    parameter int OUT_W  = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_vld,
    input logic [2*CODE_W-1:0] in_code,
    input logic                out_vld,
    input logic [OUT_W-1:0]    out_data,
    input logic                out_ovf,
    input logic                out_pol
);
    int chk_raw;
    assign chk_raw = int'(in_code[2*CODE_W-1:CODE_W]) * (1 << SHIFT)
                   + int'(in_code[CODE_W-1:0]) - OFFSET;

    // R6
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    // R6
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_data) && $stable(out_ovf) && $stable(out_pol)));

    // R4
    pol_needs_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_pol |-> out_ovf);

    // R4
    top_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ovf && out_pol) |-> (out_data == '1));

    // R5
    bottom_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ovf && !out_pol) |-> (out_data == '0));

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && chk_raw >= 0 && chk_raw < (1 << OUT_W))
        |=> (!out_ovf && int'(out_data) == $past(chk_raw)));
endmodule

bind ec_corrector ec_corrector_chk #(
    .CODE_W (CODE_W),
    .SHIFT  (SHIFT),
    .OFFSET (OFFSET),
    .OUT_W  (OUT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_code  (in_code),
    .out_vld  (out_vld),
    .out_data (out_data),
    .out_ovf  (out_ovf),
    .out_pol  (out_pol)
);

// File: tb/ec_corrector_tb.sv
module ec_corrector_tb;
    typedef struct {
        logic [11:0] data;
        logic        ovf;
        logic        pol;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [13:0] in_code = '0;
    logic        out_vld;
    logic [11:0] out_data;
    logic        out_ovf;
    logic        out_pol;

    exp_t sb_q[$];
    exp_t last_exp = '{data: 12'd0, ovf: 1'b0, pol: 1'b0};
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    ec_corrector u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_code  (in_code),
        .out_vld  (out_vld),
        .out_data (out_data),
        .out_ovf  (out_ovf),
        .out_pol  (out_pol)
    );

    function automatic exp_t model(int c, int f);
        exp_t e;
        int   v = c * 32 + f - 48;
        if (v > 4095) begin
            e = '{data: 12'd4095, ovf: 1'b1, pol: 1'b1};
        end else if (v < 0) begin
            e = '{data: 12'd0, ovf: 1'b1, pol: 1'b0};
        end else begin
            e = '{data: 12'(v), ovf: 1'b0, pol: 1'b0};
        end
        return e;
    endfunction

    task automatic check(string req, logic [13:0] act, logic [13:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one input per call, applied on the falling edge
    task automatic drive(int c, int f);
        @(negedge clk);
        in_vld  = 1'b1;
        in_code = {7'(c), 7'(f)};
        sb_q.push_back(model(c, f));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld  = 1'b0;
            in_code = 14'h2AAA ^ 14'(i * 977);
        end
    endtask

    // monitor: samples on the falling edge after each capturing rising edge
    initial begin
        bit prev_vld = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && prev_vld) begin
                if (out_vld) begin
                    exp_t e;
                    if (sb_q.size() == 0) begin
                        check("R6 extra strobe", 14'(out_vld), 14'd0);
                    end else begin
                        e = sb_q.pop_front();
                        last_exp = e;
                        check("R2/R3/R4/R5/R8 data", 14'(out_data), 14'(e.data));
                        check("R4/R5 ovf", 14'(out_ovf), 14'(e.ovf));
                        check("R4/R5 pol", 14'(out_pol), 14'(e.pol));
                    end
                end else begin
                    // R7: outputs held while idle
                    check("R7 hold data", 14'(out_data), 14'(last_exp.data));
                    check("R7 hold flags", {12'd0, out_ovf, out_pol},
                          {12'd0, last_exp.ovf, last_exp.pol});
                end
            end
            prev_vld = rst_n;
        end
    end

    // R6: strobe pulse shape, one cycle after each valid input
    initial begin
        bit vld_seen = 1'b0;
        forever begin
            @(posedge clk);
            vld_seen = in_vld;
            @(negedge clk);
            if (rst_n) check("R6 strobe", 14'(out_vld), 14'(vld_seen));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset vld", 14'(out_vld), 14'd0);
        check("R1 reset data", 14'(out_data), 14'd0);
        check("R1 reset flags", {12'd0, out_ovf, out_pol}, 14'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {out_vld, out_data, out_ovf}, 14'd0);

        // R8: boundaries
        drive(0, 48);   idle(2);   // exactly 0
        drive(127, 79); idle(2);   // exactly 4095
        drive(127, 80); idle(2);   // 4096 -> R4
        drive(0, 47);   idle(2);   // -1 -> R5
        // R4/R5 extremes
        drive(127, 127); idle(1);
        drive(0, 0);     idle(1);
        // R3 midrange, R2 field split
        drive(64, 64);  idle(1);
        drive(1, 0);    idle(1);
        drive(0, 127);  idle(3);
        // R6 back-to-back
        drive(10, 20); drive(127, 127); drive(0, 5); drive(100, 33);
        idle(4);
        // sweep
        for (int c = 0; c < 128; c += 3) begin
            drive(c, (c * 37 + 11) % 128);
            if (c % 2 == 0) idle(1);
        end
        idle(5);
        check("R6 queue drained", 14'(sb_q.size()), 14'd0);
        finish_run();
    end
endmodule